// File: doc/BRIEF.md
# Dual-Metric Carrier Sense Detector

This block decides, once per received symbol, whether a wanted signal is present. An upstream demodulator supplies two quality metrics with a valid strobe: a bit-sync amplitude, where a larger value means a stronger signal, and a phase error, where a smaller value means less phase noise and so a better signal-to-noise ratio. Each metric is compared against its own programmable 16-bit threshold. The carrier sense output is asserted only when both comparisons pass for the same strobe. It is registered, and it keeps its value between strobes.

Each threshold is loaded as two bytes through a small byte-wide write port. A high-byte write is only held in a staging register. The following low-byte write to the same threshold moves both bytes into the active threshold in one step, so the comparators never see a half-written value. The two comparisons work in opposite directions. With an amplitude threshold of 0000h the amplitude check always passes. With a phase-error threshold of FFFFh the phase check always passes. Software can use this to tune one threshold while the other check is forced to pass.

Top module: `carrier_sense_det`

## Requirements
- R1: While `rst` is high, `csense` is 0 on the following cycle. Reset sets the active amplitude threshold to 0000h and the active phase threshold to FFFFh. It also sets the amplitude staging byte to 00h and the phase staging byte to FFh.
- R2: The amplitude check passes when `met_amp`, taken as unsigned, is greater than or equal to the active amplitude threshold.
- R3: The phase check passes when `met_phase`, taken as unsigned, is less than or equal to the active phase threshold.
- R4: At each rising edge where `met_valid` is 1, `csense` is loaded with the AND of the amplitude check and the phase check. The new value is visible after that edge.
- R5: At a rising edge where `met_valid` is 0, `csense` keeps its value, whatever the metric inputs do.
- R6: A write to a high-byte address only updates that threshold's staging byte and does not change the active threshold. A write to a low-byte address makes the active threshold {staging byte, `cfg_wdata`}.
- R7: `cfg_addr` bit 1 selects the threshold (0 = amplitude, 1 = phase). Bit 0 selects the byte (0 = high, 1 = low). A write to one threshold never changes the other.
- R8: When a low-byte write and `met_valid` occur in the same cycle, the comparison uses the threshold that was active before that write.
- R9: An amplitude threshold of 0000h makes every amplitude value pass. A phase threshold of FFFFh makes every phase value pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Threshold byte write enable |
| cfg_addr | input | 2 | Byte register select: bit 1 picks the threshold, bit 0 picks the byte (0 high, 1 low) |
| cfg_wdata | input | 8 | Byte to write |
| met_valid | input | 1 | Metric valid strobe, one per symbol |
| met_amp | input | 16 | Bit-sync amplitude metric, unsigned |
| met_phase | input | 16 | Phase error metric, unsigned |
| csense | output | 1 | Registered carrier sense |

## Verification
The bench targets metric values exactly on each threshold and one count either side of it. A strict comparison, or a comparison the wrong way round, changes the result for those values. It writes a high byte alone and then strobes: a design without staging would apply the half-written threshold and would report a different carrier sense. It strobes in the same cycle as a low-byte write, where a design that forwards the new value would use the new threshold a cycle early. It also toggles the metrics while no strobe is present. A design whose output follows the comparators directly would change `csense` there.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int unsigned NUM_THR = 2;
    localparam int unsigned THR_AMP = 0;
    localparam int unsigned THR_PH  = 1;

    // cfg_addr encoding: bit 1 = threshold index, bit 0 = byte (0 high, 1 low)
    typedef enum logic [1:0] {
        REG_AMP_HI = 2'd0,
        REG_AMP_LO = 2'd1,
        REG_PH_HI  = 2'd2,
        REG_PH_LO  = 2'd3
    } cfg_reg_e;

    typedef enum logic {
        PASS_AT_LEAST = 1'b0,
        PASS_AT_MOST  = 1'b1
    } cmp_dir_e;

    typedef struct packed {
        logic hi_we;
        logic lo_we;
    } byte_wr_t;

    function automatic cmp_dir_e dir_of(input int unsigned idx);
        return (idx == THR_AMP) ? PASS_AT_LEAST : PASS_AT_MOST;
    endfunction

    function automatic byte_wr_t decode_wr(input logic we, input logic [1:0] addr,
                                           input int unsigned idx);
        byte_wr_t r;
        r.hi_we = we && (addr[1] == idx[0]) && !addr[0];
        r.lo_we = we && (addr[1] == idx[0]) &&  addr[0];
        return r;
    endfunction

endpackage

// File: rtl/csd_thresh_slot.sv
module csd_thresh_slot
    import csd_pkg::*;
#(
    parameter int unsigned THR_W   = 16,
    parameter int unsigned BYTE_W  = THR_W / 2,
    parameter logic [THR_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_wr_t          wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [THR_W-1:0]  thr
);
    localparam int unsigned HI_W = THR_W - BYTE_W;

    logic [HI_W-1:0]  stage_q;
    logic [THR_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RST_VAL[THR_W-1:BYTE_W];
            thr_q   <= RST_VAL;
        end else begin
            if (wr.hi_we) stage_q <= wdata[HI_W-1:0];
            if (wr.lo_we) thr_q   <= {stage_q, wdata};
        end
    end

    assign thr = thr_q;
endmodule

// File: rtl/csd_compare.sv
module csd_compare
    import csd_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter cmp_dir_e    DIR = PASS_AT_LEAST
) (
    input  logic [W-1:0] metric,
    input  logic [W-1:0] thr,
    output logic         pass
);
    generate
        if (DIR == PASS_AT_LEAST) begin : g_ge
            assign pass = (metric >= thr);
        end else begin : g_le
            assign pass = (metric <= thr);
        end
    endgenerate
endmodule

// File: rtl/csd_sense_reg.sv
module csd_sense_reg #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic [N-1:0] pass,
    output logic         sense
);
    logic sense_q;

    always_ff @(posedge clk) begin
        if (rst)        sense_q <= 1'b0;
        else if (valid) sense_q <= &pass;
    end

    assign sense = sense_q;
endmodule

// File: rtl/carrier_sense_det.sv
module carrier_sense_det
    import csd_pkg::*;
#(
    parameter int unsigned MET_W       = 16,
    parameter logic [MET_W-1:0] AMP_RST = '0,
    parameter logic [MET_W-1:0] PH_RST  = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [MET_W/2-1:0] cfg_wdata,
    input  logic               met_valid,
    input  logic [MET_W-1:0]   met_amp,
    input  logic [MET_W-1:0]   met_phase,
    output logic               csense
);
    localparam int unsigned BYTE_W = MET_W / 2;

    logic [MET_W-1:0] thr_act [NUM_THR];
    logic [MET_W-1:0] metric  [NUM_THR];
    logic [NUM_THR-1:0] pass;

    assign metric[THR_AMP] = met_amp;
    assign metric[THR_PH]  = met_phase;

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam logic [MET_W-1:0] RV = (g == THR_AMP) ? AMP_RST : PH_RST;
        byte_wr_t wr;
        assign wr = decode_wr(cfg_we, cfg_addr, g);

        csd_thresh_slot #(
            .THR_W  (MET_W),
            .BYTE_W (BYTE_W),
            .RST_VAL(RV)
        ) slot_i (
            .clk  (clk),
            .rst  (rst),
            .wr   (wr),
            .wdata(cfg_wdata),
            .thr  (thr_act[g])
        );

        csd_compare #(
            .W  (MET_W),
            .DIR(dir_of(g))
        ) cmp_i (
            .metric(metric[g]),
            .thr   (thr_act[g]),
            .pass  (pass[g])
        );
    end

    csd_sense_reg #(.N(NUM_THR)) sense_i (
        .clk  (clk),
        .rst  (rst),
        .valid(met_valid),
        .pass (pass),
        .sense(csense)
    );
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int unsigned MET_W = 16,
    parameter logic [MET_W-1:0] AMP_RST = '0,
    parameter logic [MET_W-1:0] PH_RST  = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic             met_valid,
    input logic [MET_W-1:0] met_amp,
    input logic [MET_W-1:0] met_phase,
    input logic [MET_W-1:0] amp_thr,
    input logic [MET_W-1:0] ph_thr,
    input logic             csense
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!csense && amp_thr == AMP_RST && ph_thr == PH_RST));

    // R2 R3 R4 R8
    a_r4_and_of_checks: assert property (@(posedge clk) disable iff (rst)
        met_valid |=> (csense == (($past(met_amp) >= $past(amp_thr)) &&
                                  ($past(met_phase) <= $past(ph_thr)))));

    // R5
    a_r5_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !met_valid |=> $stable(csense));

    // R6
    a_r6_hi_amp_staged: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd0) |=> $stable(amp_thr));

    a_r6_hi_ph_staged: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd2) |=> $stable(ph_thr));

    // R7
    a_r7_amp_wr_keeps_ph: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_addr[1]) |=> $stable(ph_thr));

    a_r7_ph_wr_keeps_amp: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr[1]) |=> $stable(amp_thr));

    // R9
    a_r9_open_thresholds: assert property (@(posedge clk) disable iff (rst)
        (met_valid && amp_thr == '0 && ph_thr == '1) |=> csense);
endmodule

bind carrier_sense_det csd_checker #(
    .MET_W  (MET_W),
    .AMP_RST(AMP_RST),
    .PH_RST (PH_RST)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .met_valid(met_valid),
    .met_amp  (met_amp),
    .met_phase(met_phase),
    .amp_thr  (thr_act[0]),
    .ph_thr   (thr_act[1]),
    .csense   (csense)
);

// File: tb/carrier_sense_det_tb.sv
module carrier_sense_det_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {amp, phase, expected csense}; thresholds amp 1234h, phase 0800h
    localparam logic [32:0] VECS [NVEC] = '{
        {16'h1234, 16'h0800, 1'b1},
        {16'h1233, 16'h0800, 1'b0},
        {16'h1234, 16'h0801, 1'b0},
        {16'hFFFF, 16'h0000, 1'b1},
        {16'h0000, 16'h0000, 1'b0},
        {16'h1235, 16'h07FF, 1'b1},
        {16'h1233, 16'h0801, 1'b0},
        {16'h8000, 16'h0800, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        met_valid = 1'b0;
    logic [15:0] met_amp = 16'd0;
    logic [15:0] met_phase = 16'd0;
    logic        csense;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    carrier_sense_det dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .met_valid(met_valid), .met_amp(met_amp),
        .met_phase(met_phase), .csense(csense)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: csense=%b expected %b", req, act, exp);
        end
    endtask

    // drive after falling edge, sample 1 time unit after the rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input logic [15:0] a, input logic [15:0] p);
        @(negedge clk);
        met_valid = 1'b1; met_amp = a; met_phase = p;
        step();
        @(negedge clk);
        met_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", csense, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R9: reset thresholds pass everything
        strobe(16'h0000, 16'hFFFF);
        check("R1 R9 reset thresholds open", csense, 1'b1);

        // R6: high byte alone is only staged
        wr(2'd0, 8'hFF);
        strobe(16'h0001, 16'h0000);
        check("R6 hi byte staged only", csense, 1'b1);
        wr(2'd1, 8'h00);
        strobe(16'hFEFF, 16'h0000);
        check("R6 R2 lo byte commits FF00", csense, 1'b0);
        strobe(16'hFF00, 16'h0000);
        check("R2 amp equal passes", csense, 1'b1);

        // R7: phase writes leave amplitude threshold alone
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h10);
        strobe(16'hFF00, 16'h0010);
        check("R7 R3 phase equal passes", csense, 1'b1);
        strobe(16'hFF00, 16'h0011);
        check("R3 phase above fails", csense, 1'b0);
        strobe(16'hFEFF, 16'h0010);
        check("R7 amp threshold kept", csense, 1'b0);

        // R5: hold without strobe
        @(negedge clk);
        met_amp = 16'hFFFF; met_phase = 16'h0000;
        repeat (3) step();
        check("R5 hold low", csense, 1'b0);
        strobe(16'hFFFF, 16'h0000);
        check("R4 both pass", csense, 1'b1);
        @(negedge clk);
        met_amp = 16'h0000; met_phase = 16'hFFFF;
        repeat (3) step();
        check("R5 hold high", csense, 1'b1);

        // R8: strobe and low write in same cycle use old threshold (0010h)
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h00;
        met_valid = 1'b1; met_amp = 16'hFF00; met_phase = 16'h0010;
        step();
        check("R8 old threshold used", csense, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;
        step();
        check("R8 new threshold next strobe", csense, 1'b0);
        @(negedge clk);
        met_valid = 1'b0;

        // table: thresholds amp 1234h, phase 0800h
        wr(2'd0, 8'h12); wr(2'd1, 8'h34);
        wr(2'd2, 8'h08); wr(2'd3, 8'h00);
        for (int i = 0; i < NVEC; i++) begin
            strobe(VECS[i][32:17], VECS[i][16:1]);
            check("R2 R3 R4 table", csense, VECS[i][0]);
        end

        // R9: open both thresholds explicitly
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        strobe(16'h0000, 16'hFFFF);
        check("R9 open thresholds", csense, 1'b1);

        // R1: reset mid-run clears csense and restores thresholds
        wr(2'd0, 8'h50); wr(2'd1, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        step();
        check("R1 reset mid-run", csense, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        strobe(16'h0000, 16'hFFFF);
        check("R1 thresholds restored", csense, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule